// File: doc/BRIEF.md
# Tiled Address Channel Swizzler

This block rewrites bit 6 of a byte address for a memory system that interleaves two channels, so that tiled surfaces land on the channel the memory controller expects. For tiled accesses, the new bit 6 is the old bit 6 XORed with a set of higher address bits. That set depends on the tiling direction and on how the memory controller is configured. Every other address bit passes through unchanged.

A configuration word holds the following fields:
- a generation code
- the channel addressing mode
- a channel-XOR disable flag
- a flag that selects bit 17 in place of bit 11
- the top rank boundary of each of the two channels

When `cfg_load_i` is sampled high on a rising clock edge, the block decodes the word into one swizzle mode for X tiling and one for Y tiling, and registers both. The address path is purely combinational from those registered modes and the per-access tiling input. A configuration the block cannot interpret yields the unknown mode. A tiled access under the unknown mode is carried out as linear and is flagged on `force_linear_o`.

Top module: `chan_swizzle`

## Requirements
- R1: Swizzle modes are coded as follows, with the taps XORed into bit 6: 0 none; 1 bit 9; 2 bits 9 and 10; 3 bits 9 and 11; 4 bits 9, 10 and 11; 5 unknown (no taps); 6 bits 9 and 17; 7 bits 9, 10 and 17. `addr_o` equals `addr_i` except bit 6, which is `addr_i[6]` XOR the taps of the mode on `mode_o`.
- R2: Tiling code 0 is linear, 1 is X and 2 is Y; code 3 is treated as linear. A linear access gives `mode_o` = 0 and `addr_o` = `addr_i`.
- R3: The configuration word is `{rank_b[15:0], rank_a[15:0], sel17, xor_dis, chan_mode[1:0], gen[3:0]}`, with gen in bits 3:0. Gen 6 and above, and gen 2 and below, give mode 0 for both tiling directions. Gen 5 gives X mode 2 and Y mode 1, whatever the other fields hold.
- R4: For gen 3, channel mode 0 (single channel), 1 (dual channel, asymmetric) or 3 (reserved) gives mode 0 for both directions.
- R5: For gen 3 with channel mode 2 (dual channel, interleaved) and xor_dis = 1, X uses mode 2 and Y uses mode 1.
- R6: For gen 3 with channel mode 2 and xor_dis = 0: if sel17 = 0, X uses mode 4 and Y uses mode 3; if sel17 = 1, X uses mode 7 and Y uses mode 6.
- R7: For gen 4, rank_a ≠ rank_b gives mode 0 for both directions; rank_a = rank_b gives X mode 2 and Y mode 1.
- R8: A configuration word of all ones decodes to mode 5 for both directions. A tiled access under mode 5 gives `force_linear_o` = 1, `mode_o` = 0 and `addr_o` = `addr_i`. `force_linear_o` is 0 in every other case.
- R9: After reset both registered modes are 0. They take new values only at a rising edge with `cfg_load_i` high, and are visible from that edge on. A change on `cfg_i` without a load has no effect.
- R10: With the modes held, `addr_o`, `mode_o` and `force_linear_o` follow `addr_i` and `tiling_i` within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_load_i | input | 1 | Registers the modes decoded from `cfg_i` |
| cfg_i | input | CFG_W (40) | Memory-controller configuration word |
| tiling_i | input | 2 | 0 linear, 1 X, 2 Y, 3 linear |
| addr_i | input | ADDR_W (32) | Byte address in |
| mode_o | output | 3 | Swizzle mode applied to this access |
| force_linear_o | output | 1 | Tiled access demoted to linear (unknown mode) |
| addr_o | output | ADDR_W (32) | Swizzled byte address |

## Verification
A wrong registered mode is visible on `mode_o` from the first tiled access after the load edge. It is also visible on `addr_o` as soon as an address has a tap bit set that differs between the right mode and the wrong one. For that reason every configuration is followed by a sweep over all 32 combinations of bits 6, 9, 10, 11 and 17, in each tiling direction. A wrong tap set shows up within that sweep on bit 6 alone. A load that is missed, or that happens when it should not, shows one cycle later as a stale mode.

// File: rtl/swz_pkg.sv
package swz_pkg;
  typedef enum logic [2:0] {
    SWZ_NONE     = 3'd0,
    SWZ_9        = 3'd1,
    SWZ_9_10     = 3'd2,
    SWZ_9_11     = 3'd3,
    SWZ_9_10_11  = 3'd4,
    SWZ_UNK      = 3'd5,
    SWZ_9_17     = 3'd6,
    SWZ_9_10_17  = 3'd7
  } swz_mode_e;

  typedef enum logic [1:0] {
    TILE_LIN  = 2'd0,
    TILE_X    = 2'd1,
    TILE_Y    = 2'd2,
    TILE_RSVD = 2'd3
  } tiling_e;

  localparam logic [1:0] CHM_SINGLE = 2'd0;
  localparam logic [1:0] CHM_ASYM   = 2'd1;
  localparam logic [1:0] CHM_ILV    = 2'd2;

  localparam int GEN_CHAN_DEC = 3;
  localparam int GEN_RANK_CMP = 4;
  localparam int GEN_FIXED    = 5;
  localparam int GEN_NO_SWZ   = 6;

  // tap vector order: {b17, b11, b10, b9}
  function automatic logic [3:0] taps_of(swz_mode_e m);
    case (m)
      SWZ_9:       taps_of = 4'b0001;
      SWZ_9_10:    taps_of = 4'b0011;
      SWZ_9_11:    taps_of = 4'b0101;
      SWZ_9_10_11: taps_of = 4'b0111;
      SWZ_9_17:    taps_of = 4'b1001;
      SWZ_9_10_17: taps_of = 4'b1011;
      default:     taps_of = 4'b0000;
    endcase
  endfunction
endpackage

// File: rtl/swz_cfg_decode.sv
module swz_cfg_decode
  import swz_pkg::*;
#(
  parameter int GEN_W  = 4,
  parameter int RANK_W = 16,
  localparam int CFG_W = GEN_W + 4 + 2 * RANK_W
) (
  input  logic [CFG_W-1:0] cfg_i,
  output swz_mode_e        x_mode_o,
  output swz_mode_e        y_mode_o
);
  localparam int CHM_LSB   = GEN_W;
  localparam int XDIS_BIT  = GEN_W + 2;
  localparam int SEL17_BIT = GEN_W + 3;
  localparam int RKA_LSB   = GEN_W + 4;
  localparam int RKB_LSB   = RKA_LSB + RANK_W;

  logic [GEN_W-1:0]  gen;
  logic [1:0]        chm;
  logic              xor_dis, sel17;
  logic [RANK_W-1:0] rank_a, rank_b;

  assign gen     = cfg_i[GEN_W-1:0];
  assign chm     = cfg_i[CHM_LSB +: 2];
  assign xor_dis = cfg_i[XDIS_BIT];
  assign sel17   = cfg_i[SEL17_BIT];
  assign rank_a  = cfg_i[RKA_LSB +: RANK_W];
  assign rank_b  = cfg_i[RKB_LSB +: RANK_W];

  always_comb begin
    x_mode_o = SWZ_NONE;
    y_mode_o = SWZ_NONE;
    if (&cfg_i) begin
      x_mode_o = SWZ_UNK;
      y_mode_o = SWZ_UNK;
    end else if (int'(gen) >= GEN_NO_SWZ) begin
      x_mode_o = SWZ_NONE;
      y_mode_o = SWZ_NONE;
    end else if (int'(gen) == GEN_FIXED) begin
      x_mode_o = SWZ_9_10;
      y_mode_o = SWZ_9;
    end else if (int'(gen) == GEN_RANK_CMP) begin
      if (rank_a == rank_b) begin
        x_mode_o = SWZ_9_10;
        y_mode_o = SWZ_9;
      end
    end else if (int'(gen) == GEN_CHAN_DEC && chm == CHM_ILV) begin
      if (xor_dis) begin
        x_mode_o = SWZ_9_10;
        y_mode_o = SWZ_9;
      end else if (!sel17) begin
        x_mode_o = SWZ_9_10_11;
        y_mode_o = SWZ_9_11;
      end else begin
        x_mode_o = SWZ_9_10_17;
        y_mode_o = SWZ_9_17;
      end
    end
  end
endmodule

// File: rtl/swz_mode_regs.sv
module swz_mode_regs
  import swz_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      load_i,
  input  swz_mode_e x_d_i,
  input  swz_mode_e y_d_i,
  output swz_mode_e x_q_o,
  output swz_mode_e y_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q_o <= SWZ_NONE;
      y_q_o <= SWZ_NONE;
    end else if (load_i) begin
      x_q_o <= x_d_i;
      y_q_o <= y_d_i;
    end
  end

  // R9
  hold_without_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(x_q_o) && $stable(y_q_o)));

  // R8
  unknown_paired_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_q_o == SWZ_UNK) == (y_q_o == SWZ_UNK));

  // R5 R6 R7: X never uses a mode without bit 10 other than none/unknown
  x_mode_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(x_q_o inside {SWZ_9, SWZ_9_11, SWZ_9_17}));

  // R5 R6 R7: Y never taps bit 10
  y_mode_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(y_q_o inside {SWZ_9_10, SWZ_9_10_11, SWZ_9_10_17}));
endmodule

// File: rtl/swz_bit6_xor.sv
module swz_bit6_xor
  import swz_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  swz_mode_e         mode_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int NTAP = 4;
  localparam int TAP_POS [NTAP] = '{9, 10, 11, 17};

  logic [NTAP-1:0] taps, hits;

  assign taps = taps_of(mode_i);

  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    assign hits[g] = taps[g] & addr_i[TAP_POS[g]];
  end

  always_comb begin
    addr_o    = addr_i;
    addr_o[6] = addr_i[6] ^ (^hits);
  end
endmodule

// File: rtl/chan_swizzle.sv
module chan_swizzle
  import swz_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int GEN_W  = 4,
  parameter int RANK_W = 16,
  localparam int CFG_W = GEN_W + 4 + 2 * RANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_load_i,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic [1:0]        tiling_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [2:0]        mode_o,
  output logic              force_linear_o,
  output logic [ADDR_W-1:0] addr_o
);
  swz_mode_e x_dec, y_dec, x_q, y_q, sel_mode, app_mode;

  swz_cfg_decode #(.GEN_W(GEN_W), .RANK_W(RANK_W)) u_dec (
    .cfg_i    (cfg_i),
    .x_mode_o (x_dec),
    .y_mode_o (y_dec)
  );

  swz_mode_regs u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cfg_load_i),
    .x_d_i  (x_dec),
    .y_d_i  (y_dec),
    .x_q_o  (x_q),
    .y_q_o  (y_q)
  );

  always_comb begin
    case (tiling_e'(tiling_i))
      TILE_X:  sel_mode = x_q;
      TILE_Y:  sel_mode = y_q;
      default: sel_mode = SWZ_NONE;
    endcase
    force_linear_o = (sel_mode == SWZ_UNK);
    app_mode       = force_linear_o ? SWZ_NONE : sel_mode;
  end

  assign mode_o = app_mode;

  swz_bit6_xor #(.ADDR_W(ADDR_W)) u_xor (
    .addr_i (addr_i),
    .mode_i (app_mode),
    .addr_o (addr_o)
  );

  // R1
  only_bit6_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((addr_o ^ addr_i) & ~(ADDR_W'(1) << 6)) == '0);

  // R2
  linear_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tiling_i == 2'd0 || tiling_i == 2'd3) |-> (addr_o == addr_i && mode_o == 3'd0));

  // R8
  forced_linear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_linear_o |-> (addr_o == addr_i && mode_o == 3'd0 && tiling_i inside {2'd1, 2'd2}));
endmodule

// File: tb/chan_swizzle_bench.sv
`timescale 1ns/1ps
module chan_swizzle_bench;
  localparam int ADDR_W = 32;
  localparam int CFG_W  = 40;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              load = 1'b0;
  logic [CFG_W-1:0]  cfg = '0;
  logic [1:0]        tiling = 2'd0;
  logic [ADDR_W-1:0] addr = '0;
  logic [2:0]        mode;
  logic              fl;
  logic [ADDR_W-1:0] addr_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  chan_swizzle u_chan_swizzle (
    .clk_i(clk), .rst_ni(rst_n), .cfg_load_i(load), .cfg_i(cfg),
    .tiling_i(tiling), .addr_i(addr), .mode_o(mode),
    .force_linear_o(fl), .addr_o(addr_out)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [CFG_W-1:0] mk_cfg(int gen, int chm, int xd, int s17, logic [15:0] ra, logic [15:0] rb);
    return {rb, ra, 1'(s17), 1'(xd), 2'(chm), 4'(gen)};
  endfunction

  // expected {x,y} modes from the requirement text
  function automatic logic [5:0] exp_modes(logic [CFG_W-1:0] c);
    int gen = int'(c[3:0]);
    int chm = int'(c[5:4]);
    if (&c) return {3'd5, 3'd5};
    if (gen == 5) return {3'd2, 3'd1};
    if (gen == 4) return (c[23:8] == c[39:24]) ? {3'd2, 3'd1} : 6'd0;
    if (gen == 3 && chm == 2) begin
      if (c[6]) return {3'd2, 3'd1};
      return c[7] ? {3'd7, 3'd6} : {3'd4, 3'd3};
    end
    return 6'd0;
  endfunction

  function automatic string req_of(logic [CFG_W-1:0] c);
    int gen = int'(c[3:0]);
    if (&c) return "R8";
    if (gen == 4) return "R7";
    if (gen == 3) begin
      if (c[5:4] != 2'd2) return "R4";
      return c[6] ? "R5" : "R6";
    end
    return "R3";
  endfunction

  function automatic logic [ADDR_W-1:0] exp_addr(logic [ADDR_W-1:0] a, logic [2:0] m);
    logic b = a[6];
    case (m)
      3'd1: b = b ^ a[9];
      3'd2: b = b ^ a[9] ^ a[10];
      3'd3: b = b ^ a[9] ^ a[11];
      3'd4: b = b ^ a[9] ^ a[10] ^ a[11];
      3'd6: b = b ^ a[9] ^ a[17];
      3'd7: b = b ^ a[9] ^ a[10] ^ a[17];
      default: ;
    endcase
    return {a[31:7], b, a[5:0]};
  endfunction

  function automatic logic [ADDR_W-1:0] pat(int k);
    logic [ADDR_W-1:0] m = 32'h0002_0E40;
    logic [ADDR_W-1:0] bg = (32'h5A3C_F1B7 + 32'(k) * 32'h0101_0203) & ~m;
    return bg | (32'(k & 1) << 6) | (32'((k >> 1) & 1) << 9) | (32'((k >> 2) & 1) << 10)
              | (32'((k >> 3) & 1) << 11) | (32'((k >> 4) & 1) << 17);
  endfunction

  task automatic do_load(input logic [CFG_W-1:0] c);
    @(negedge clk);
    cfg = c;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic sweep(input logic [CFG_W-1:0] c);
    logic [5:0] em = exp_modes(c);
    string rq = req_of(c);
    for (int t = 0; t < 4; t++) begin
      logic [2:0] sel = (t == 1) ? em[5:3] : (t == 2) ? em[2:0] : 3'd0;
      logic efl = (sel == 3'd5);
      logic [2:0] app = efl ? 3'd0 : sel;
      string mrq = (t == 0 || t == 3) ? "R2" : rq;
      tiling = 2'(t);
      for (int k = 0; k < 32; k++) begin
        addr = pat(k);
        #1;
        // R10: combinational follow of addr/tiling
        chk(mode == app, {mrq, " mode"}, longint'(mode), longint'(app));
        chk(fl == efl, {"R8 force_linear ", mrq}, longint'(fl), longint'(efl));
        chk(addr_out == exp_addr(addr, app), {"R1 addr R10 ", mrq},
            longint'(addr_out), longint'(exp_addr(addr, app)));
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state is mode none
    tiling = 2'd1;
    addr = 32'h0000_0600;
    #1;
    chk(mode == 3'd0 && !fl, "R9 reset mode", longint'(mode), 0);
    chk(addr_out == addr, "R9 reset addr", longint'(addr_out), longint'(addr));
    rst_n = 1'b1;
    @(negedge clk);
    chk(mode == 3'd0 && addr_out == addr, "R9 after reset release", longint'(addr_out), longint'(addr));

    for (int g = 0; g < 16; g++)
      for (int ch = 0; ch < 4; ch++)
        for (int xd = 0; xd < 2; xd++)
          for (int s = 0; s < 2; s++)
            for (int rk = 0; rk < 2; rk++) begin
              logic [CFG_W-1:0] c = mk_cfg(g, ch, xd, s, 16'h0400, rk ? 16'h0400 : 16'h0200);
              do_load(c);
              sweep(c);
            end

    // R8: all-ones word
    do_load('1);
    sweep('1);

    // R9: change cfg without load has no effect
    do_load(mk_cfg(3, 2, 0, 1, 16'h0, 16'h1));
    cfg = '1;
    tiling = 2'd1;
    addr = 32'h0002_0000;
    repeat (3) @(negedge clk);
    #1;
    chk(mode == 3'd7 && !fl, "R9 no-load hold mode", longint'(mode), 7);
    chk(addr_out == 32'h0002_0040, "R9 no-load hold addr", longint'(addr_out), 32'h0002_0040);
    tiling = 2'd2;
    #1;
    chk(mode == 3'd6, "R9 no-load hold Y", longint'(mode), 6);
    // R9: load takes effect at the edge
    @(negedge clk);
    load = 1'b1;
    @(posedge clk);
    #1;
    chk(fl == 1'b1 && mode == 3'd0, "R9 load visible after edge", longint'(fl), 1);
    load = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule